// File: doc/BRIEF.md
# Control Pulse Long/Short Classifier

This block sorts the pulses of a playback control track into long and short. A prescaled counter times the high phase of each pulse. When the pulse falls, the upper bits of that count are compared with two thresholds, one for a "1" and one for a "0". The tape direction input picks which pair of thresholds applies. The two comparison outcomes are held in set/reset latches. On the next rising edge of the pulse they are turned into one result bit.

Each result is shifted into an eight-bit pattern register from the low end. A ready flag goes up once eight results have been collected since the pattern was last read. Software programs the four thresholds, polls the status register for the flag and then reads the pattern. That read clears the flag and restarts the count of collected results. The register port is a plain single-cycle access: a write takes effect at the clock edge, and read data is combinational from the address. The pulse input has no back-pressure, and every rising edge that follows a measured pulse produces exactly one result.

Top module: `ctl_ls_classifier`

## Requirements
- R1: The four threshold registers are 12 bits wide and read back what was written. The addresses are: 0 forward "1" threshold, 1 forward "0" threshold, 2 reverse "0" threshold, 3 reverse "1" threshold. Writes to address 4 (pattern) and address 5 (status) have no effect. After reset all registers read 0.
- R2: The pulse timer is a 16-bit counter. It clears in the cycle the rising edge of `ctl_pulse` is seen. After that it counts up by one in each cycle where `ctl_pulse` is high and `tick_en` is 1. It holds while the pulse is low.
- R3: The counter saturates at 0xFFFF instead of wrapping, so a very long pulse is still classified as long.
- R4: Only counter bits [15:4] are compared. The comparisons are taken at the falling edge and latched. A result of 1 applies when those bits are greater than or equal to the active "1" threshold. This takes priority over the "0" rule.
- R5: A result of 0 applies when the compared bits are less than or equal to the active "0" threshold. A pulse that falls between the two thresholds repeats the previous result, which is pattern bit 0.
- R6: `dir_rev`=0 selects the forward thresholds (addresses 0 and 1). `dir_rev`=1 selects the reverse thresholds (addresses 3 and 2). The direction is sampled at the falling edge.
- R7: A result is produced only on a rising edge of `ctl_pulse` that follows a falling edge. At that edge the pattern (address 4, bits [7:0]) shifts left by one and the result enters bit 0. The pattern is unchanged at all other times.
- R8: Status bit 1 (address 5) is the ready flag. It sets on every eighth result and stays set. A read of address 4 clears both the flag and the result count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only side effect: reading address 4 clears the ready flag) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data for `reg_addr`, combinational |
| ctl_pulse | input | 1 | Synchronized playback control pulse |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| tick_en | input | 1 | Counter advance enable (quarter-rate prescale) |

## Verification
The bench drives pulses whose high times land above the "1" threshold, below the "0" threshold and in the dead band between them. A design that cleared or zeroed the previous bit in the dead band would show a wrong pattern. It swaps direction between pulses, which catches a swapped threshold pair or a direction sampled at the wrong edge. It also holds one pulse high past 65536 counts: a wrapping counter would land inside the "0" range there and record a 0. A ready-flag sequence checks that the flag stays low after seven results, rises on the eighth and clears on a pattern read. A quarter-rate enable shows whether the counter ignores `tick_en`.

// File: rtl/ctl_ls_pkg.sv
package ctl_ls_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_FWD_ONE  = 3'd0,
    A_FWD_ZERO = 3'd1,
    A_REV_ZERO = 3'd2,
    A_REV_ONE  = 3'd3,
    A_PATTERN  = 3'd4,
    A_STATUS   = 3'd5
  } reg_addr_e;

  localparam int NUM_THR   = 4;
  localparam int READY_BIT = 1;
endpackage

// File: rtl/ctl_ls_regs.sv
module ctl_ls_regs
  import ctl_ls_pkg::*;
#(
  parameter int THR_W = 12,
  parameter int PAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [THR_W-1:0]  wdata,
  input  logic              dir_rev,
  input  logic [PAT_W-1:0]  pattern,
  input  logic              ready,
  output logic [THR_W-1:0]  rdata,
  output logic [THR_W-1:0]  thr_one,
  output logic [THR_W-1:0]  thr_zero
);
  logic [THR_W-1:0] thr_q [NUM_THR];

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        thr_q[g] <= '0;
      else if (wr && addr == ADDR_W'(g))
        thr_q[g] <= wdata;
    end
  end

  always_comb begin
    if (dir_rev) begin
      thr_one  = thr_q[A_REV_ONE];
      thr_zero = thr_q[A_REV_ZERO];
    end else begin
      thr_one  = thr_q[A_FWD_ONE];
      thr_zero = thr_q[A_FWD_ZERO];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_FWD_ONE:  rdata = thr_q[A_FWD_ONE];
      A_FWD_ZERO: rdata = thr_q[A_FWD_ZERO];
      A_REV_ZERO: rdata = thr_q[A_REV_ZERO];
      A_REV_ONE:  rdata = thr_q[A_REV_ONE];
      A_PATTERN:  rdata = THR_W'(pattern);
      A_STATUS:   rdata[READY_BIT] = ready;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/ctl_ls_timer.sv
module ctl_ls_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             tick_en,
  output logic             rise,
  output logic             fall,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_in;
  end

  assign rise = pulse_in & ~pulse_q;
  assign fall = ~pulse_in & pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (rise)
      cnt <= '0;
    else if (pulse_in && tick_en && cnt != CNT_MAX)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ctl_ls_judge.sv
module ctl_ls_judge #(
  parameter int THR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic [THR_W-1:0] hi_time,
  input  logic [THR_W-1:0] thr_one,
  input  logic [THR_W-1:0] thr_zero,
  input  logic             prev_bit,
  output logic             decide,
  output logic             result
);
  logic long_q, short_q, meas_q;

  // Set/reset latches: set by the falling-edge comparison, reset once used.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      long_q  <= 1'b0;
      short_q <= 1'b0;
      meas_q  <= 1'b0;
    end else if (fall) begin
      long_q  <= (hi_time >= thr_one);
      short_q <= (hi_time <= thr_zero);
      meas_q  <= 1'b1;
    end else if (rise) begin
      long_q  <= 1'b0;
      short_q <= 1'b0;
      meas_q  <= 1'b0;
    end
  end

  assign decide = rise & meas_q;

  always_comb begin
    if (long_q)       result = 1'b1;
    else if (short_q) result = 1'b0;
    else              result = prev_bit;
  end
endmodule

// File: rtl/ctl_ls_pattern.sv
module ctl_ls_pattern #(
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decide,
  input  logic             result,
  input  logic             rd_clear,
  output logic [PAT_W-1:0] pattern,
  output logic             ready
);
  localparam int SC_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(PAT_W - 1);

  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pattern <= '0;
    else if (decide)
      pattern <= {pattern[PAT_W-2:0], result};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q  <= '0;
      ready <= 1'b0;
    end else if (rd_clear) begin
      sc_q  <= decide ? SC_W'(1) : '0;
      ready <= 1'b0;
    end else if (decide) begin
      if (sc_q == SC_LAST) begin
        sc_q  <= '0;
        ready <= 1'b1;
      end else begin
        sc_q <= sc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_ls_classifier.sv
module ctl_ls_classifier
  import ctl_ls_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int THR_W = 12,
  parameter int PAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [THR_W-1:0]  reg_wdata,
  output logic [THR_W-1:0]  reg_rdata,
  input  logic              ctl_pulse,
  input  logic              dir_rev,
  input  logic              tick_en
);
  logic             tmr_rise, tmr_fall, jd_decide, jd_result, pat_ready, pat_clr;
  logic [CNT_W-1:0] tmr_cnt;
  logic [THR_W-1:0] act_one, act_zero;
  logic [PAT_W-1:0] pat_q;

  assign pat_clr = reg_rd && (reg_addr == A_PATTERN);

  ctl_ls_regs #(.THR_W(THR_W), .PAT_W(PAT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dir_rev(dir_rev), .pattern(pat_q), .ready(pat_ready), .rdata(reg_rdata),
    .thr_one(act_one), .thr_zero(act_zero)
  );

  ctl_ls_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .pulse_in(ctl_pulse), .tick_en(tick_en),
    .rise(tmr_rise), .fall(tmr_fall), .cnt(tmr_cnt)
  );

  ctl_ls_judge #(.THR_W(THR_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .rise(tmr_rise), .fall(tmr_fall),
    .hi_time(tmr_cnt[CNT_W-1 -: THR_W]), .thr_one(act_one), .thr_zero(act_zero),
    .prev_bit(pat_q[0]), .decide(jd_decide), .result(jd_result)
  );

  ctl_ls_pattern #(.PAT_W(PAT_W)) u_pattern (
    .clk(clk), .rst_n(rst_n), .decide(jd_decide), .result(jd_result),
    .rd_clear(pat_clr), .pattern(pat_q), .ready(pat_ready)
  );
endmodule

// File: rtl/ctl_ls_classifier_chk.sv
module ctl_ls_classifier_chk
  import ctl_ls_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_pulse,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              rise,
  input logic              decide,
  input logic [CNT_W-1:0]  cnt,
  input logic [PAT_W-1:0]  pattern,
  input logic              ready
);
  // R2
  cnt_clear_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> cnt == '0);
  // R2
  cnt_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_pulse |=> $stable(cnt));
  // R3
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && !rise) |=> cnt == '1);
  // R7
  pattern_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> pattern[PAT_W-1:1] == $past(pattern[PAT_W-2:0]));
  // R7
  pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !decide |=> $stable(pattern));
  // R8
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_PATTERN) |=> !ready);
endmodule

bind ctl_ls_classifier ctl_ls_classifier_chk #(.CNT_W(CNT_W), .PAT_W(PAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_pulse(ctl_pulse), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .rise(tmr_rise), .decide(jd_decide), .cnt(tmr_cnt),
  .pattern(pat_q), .ready(pat_ready)
);

// File: tb/ctl_ls_classifier_bench.sv
module ctl_ls_classifier_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic        ctl_pulse = 1'b0, dir_rev = 1'b0, tick_en = 1'b0;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // bench-side model
  logic [11:0] tf1, tf0, tr0, tr1;
  logic [7:0]  e_pat;
  int          e_cnt;
  bit          e_rdy, pend, m_dir;
  int          m_hi;
  int          tick;

  always #2.5 clk = ~clk;

  ctl_ls_classifier u_ctl_ls_classifier (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctl_pulse(ctl_pulse), .dir_rev(dir_rev), .tick_en(tick_en)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ctl_pulse = 1'b0; dir_rev = 1'b0; tick_en = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tf1 = '0; tf0 = '0; tr0 = '0; tr1 = '0;
    e_pat = '0; e_cnt = 0; e_rdy = 1'b0; pend = 1'b0; tick = 0;
  endtask

  task automatic wr_reg(int a, int d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wdata = 12'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      0: tf1 = 12'(d);
      1: tf0 = 12'(d);
      2: tr0 = 12'(d);
      3: tr1 = 12'(d);
      default: ;
    endcase
  endtask

  task automatic rd_reg(int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a); reg_rd = 1'b1;
    #1 v = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
    if (a == 4) begin e_cnt = 0; e_rdy = 1'b0; end
  endtask

  task automatic set_thr(int f1, int f0, int r0, int r1);
    wr_reg(0, f1); wr_reg(1, f0); wr_reg(2, r0); wr_reg(3, r1);
  endtask

  // one pulse: hi cycles high then lo cycles low; div4 drives a quarter-rate enable
  task automatic pulse(int hi, int lo, bit div4);
    int c = 0;
    for (int i = 0; i < hi; i++) begin
      @(negedge clk);
      ctl_pulse = 1'b1;
      tick_en = div4 ? (tick % 4 == 0) : 1'b1;
      tick++;
      if (i == 0) begin
        if (pend) begin
          bit b;
          logic [11:0] one = m_dir ? tr1 : tf1;
          logic [11:0] zer = m_dir ? tr0 : tf0;
          if (m_hi >= int'(one))      b = 1'b1;
          else if (m_hi <= int'(zer)) b = 1'b0;
          else                        b = e_pat[0];
          e_pat = {e_pat[6:0], b};
          e_cnt++;
          if (e_cnt == 8) begin e_cnt = 0; e_rdy = 1'b1; end
          pend = 1'b0;
        end
      end else if (tick_en && c < 65535) c++;
    end
    for (int i = 0; i < lo; i++) begin
      @(negedge clk);
      ctl_pulse = 1'b0;
      if (i == 0) begin m_hi = c >> 4; m_dir = dir_rev; pend = 1'b1; end
    end
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    for (int a = 0; a < 6; a++) begin
      rd_reg(a, v);
      check("R1 reset value", v, 0);
    end
  endtask

  task automatic t_regs();
    int v;
    do_reset();
    set_thr(12'hA5C, 12'h123, 12'hFFF, 12'h001);
    rd_reg(0, v); check("R1 fwd one", v, 12'hA5C);
    rd_reg(1, v); check("R1 fwd zero", v, 12'h123);
    rd_reg(2, v); check("R1 rev zero", v, 12'hFFF);
    rd_reg(3, v); check("R1 rev one", v, 12'h001);
    wr_reg(4, 12'hFF); wr_reg(5, 12'hFFF);
    rd_reg(4, v); check("R1 pattern write ignored", v, 0);
    rd_reg(5, v); check("R1 status write ignored", v, 0);
  endtask

  task automatic t_forward();
    int v;
    do_reset();
    set_thr(8, 4, 1, 3);
    dir_rev = 1'b0;
    pulse(200, 10, 0); // long
    pulse(40, 10, 0);  // short
    pulse(200, 10, 0); // long
    pulse(130, 10, 0); // cnt 129, hi 8: equal to one threshold
    pulse(80, 10, 0);  // cnt 79, hi 4: equal to zero threshold
    pulse(10, 10, 0);  // closes last measurement
    rd_reg(4, v);
    check("R4 R5 forward pattern", v, int'(e_pat));
    check("R4 R5 forward literal", v, 8'b10110);
  endtask

  task automatic t_between();
    int v;
    do_reset();
    set_thr(8, 4, 1, 3);
    pulse(200, 10, 0); // 1
    pulse(100, 10, 0); // hi 6: repeat 1
    pulse(40, 10, 0);  // 0
    pulse(100, 10, 0); // repeat 0
    pulse(10, 10, 0);
    rd_reg(4, v);
    check("R5 dead band repeats", v, 8'b1100);
  endtask

  task automatic t_reverse();
    int v;
    do_reset();
    set_thr(8, 4, 1, 3);
    dir_rev = 1'b1; pulse(100, 10, 0); // rev: hi 6 >= 3 -> 1
    dir_rev = 1'b0; pulse(100, 10, 0); // fwd: dead band -> 1
    dir_rev = 1'b1; pulse(30, 10, 0);  // rev: hi 1 <= 1 -> 0
    dir_rev = 1'b0; pulse(60, 10, 0);  // fwd: hi 3 <= 4 -> 0
    dir_rev = 1'b1; pulse(60, 10, 0);  // rev: hi 3 -> 1
    dir_rev = 1'b0; pulse(10, 10, 0);
    rd_reg(4, v);
    check("R6 direction pairs", v, 8'b11001);
    check("R6 model", v, int'(e_pat));
  endtask

  task automatic t_ready();
    int v;
    do_reset();
    set_thr(8, 4, 1, 3);
    pulse(200, 10, 0);
    for (int i = 0; i < 7; i++) pulse((i % 2) ? 200 : 40, 10, 0);
    rd_reg(5, v); check("R8 not ready after 7", v, 0);
    pulse(200, 10, 0);
    rd_reg(5, v); check("R8 ready after 8", v, 2);
    pulse(40, 10, 0);
    rd_reg(5, v); check("R8 ready stays set", v, 2);
    rd_reg(4, v); check("R7 pattern after 9", v, int'(e_pat));
    rd_reg(5, v); check("R8 cleared by pattern read", v, 0);
    for (int i = 0; i < 7; i++) pulse(200, 10, 0);
    rd_reg(5, v); check("R8 count restarted", v, 0);
    pulse(40, 10, 0);
    rd_reg(5, v); check("R8 ready again", v, 2);
  endtask

  task automatic t_prescale();
    int v;
    do_reset();
    set_thr(8, 4, 1, 3);
    pulse(200, 10, 1); // ~50 counts -> hi 3 -> 0 (would be 1 with every-cycle count)
    pulse(600, 10, 1); // ~150 counts -> hi 9 -> 1
    pulse(40, 10, 1);
    rd_reg(4, v);
    check("R2 quarter-rate enable", v, 8'b01);
    check("R2 model", v, int'(e_pat));
  endtask

  task automatic t_saturate();
    int v;
    do_reset();
    set_thr(12'hFFF, 12'hFFE, 0, 0);
    pulse(66000, 10, 0); // saturates; a wrap would land at hi 28 -> 0
    pulse(10, 10, 0);
    rd_reg(4, v);
    check("R3 saturation long", v, 1);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_forward();
    t_between();
    t_reverse();
    t_ready();
    t_prescale();
    t_saturate();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule